// File: doc/BRIEF.md
# Multiplexed Dynamic-Segment Minislot Arbiter

This block runs the event-triggered part of a time-division bus cycle as a minislot-counting arbiter. A host marks messages as pending with one-clock request pulses. After a segment-start pulse, the block walks through priority identifiers one minislot decision at a time, beginning at identifier 1. At each identifier it grants the bus to the pending message that owns that identifier and whose cycle filter accepts the current cycle. The grant lasts for the message's length in minislots. If no message can go at that identifier, exactly one minislot is spent and the walk moves on.

Several table entries may share one identifier. This is slot multiplexing. Each entry carries a base cycle and a power-of-two repetition rate. Together these select the bus cycles in which the entry may claim its identifier. A cycle counter advances at the end of every segment and wraps at a configured pattern length.

All configuration is supplied as plain inputs and must be held stable while segments run: segment length, pattern length, latest start minislot, and the per-entry identifier, base, rate and length. The outputs are plain pulses and levels. There is no streaming data path, so no valid/ready handshake is used.

Top module: `dynseg_arbiter`

## Requirements
- R1: After reset the cycle number is 0. It advances by one when each segment ends, and it returns to 0 after the value `cfg_cc_max`-1 (`cfg_cc_max` lies from 1 to 64).
- R2: Entry i is eligible in a cycle only when (cycle AND (2^`rep_log2`-1)) equals its base. `rep_log2` is a 3-bit field from 0 to 6 at bits [3i+2:3i], and base must be less than the rate.
- R3: A `seg_start` pulse while idle opens a segment at identifier 1. Each decision moves to the next higher identifier, so a smaller identifier always gets an earlier turn. Identifier 0 never wins.
- R4: An eligible pending entry that fits holds the bus for exactly its length in minislot ticks.
  - `gnt` pulses, with `tx_idx` set, one clock after the tick that starts it.
  - `done` pulses one clock after the tick that ends it.
  - For a length of 1, both pulses happen together.
- R5: At an identifier with no eligible pending entry, one minislot is used and the walk moves to the next identifier. The same applies when the entry's length exceeds the minislots left. The entry stays pending.
- R6: No entry is sent more than once in one segment.
- R7: Entries sharing an identifier, with filters that select different cycles, are each served in their own cycles.
- R8: A grant starts only if the number of minislots already used is at most `cfg_latest`. Later in the segment no grant is issued.
- R9: If two entries are eligible and pending for the same identifier at once, the lower table index wins and `cfg_err` is set and stays set until reset.
- R10: A `req` pulse makes an entry pending and `done` clears it. A `req` raised during that entry's own transmission is kept for a later permitted cycle.
- R11: A `seg_start` during an open segment is ignored. `ms_tick` pulses outside a segment are ignored: no grant occurs and the cycle number does not change.
- R12: A segment closes after `cfg_seg_len` ticks, and a transmission never runs past the segment end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_seg_len | input | MS_W | Minislots per segment |
| cfg_cc_max | input | CYC_W+1 | Cycle pattern length, 1..64 |
| cfg_latest | input | MS_W | Latest minislot index at which a grant may start |
| cfg_id | input | N_MSG*ID_W | Per-entry priority identifier |
| cfg_base | input | N_MSG*CYC_W | Per-entry base cycle |
| cfg_rep_log2 | input | N_MSG*3 | Per-entry log2 of repetition rate |
| cfg_len | input | N_MSG*MS_W | Per-entry length in minislots (at least 1) |
| req | input | N_MSG | Request pulses, one bit per entry |
| seg_start | input | 1 | Opens a segment |
| ms_tick | input | 1 | Start of each minislot |
| gnt | output | 1 | Grant pulse |
| done | output | 1 | Transmission-complete pulse |
| tx_idx | output | IDX_W | Entry index of the current or last grant |
| busy | output | 1 | A multi-minislot transmission is in progress |
| cycle_no | output | CYC_W | Current cycle number |
| cfg_err | output | 1 | Sticky identifier-collision flag |

## Verification
The assertions assume the following about the inputs:
- Configuration is constant while segments run.
- `cfg_cc_max` is at least 1, every length is at least 1, and every base is below its rate.
- `ms_tick` pulses are separated by idle clocks.

The stimulus programs the table once, apart from one deliberate identifier change between segments. It separates every tick by an idle clock and only reconfigures between segments. It also applies the corner cases that the input rules still allow: stray ticks between segments, a stray segment start inside an open segment, and a repeated request during the requester's own transmission.

// File: rtl/dynseg_pkg.sv
package dynseg_pkg;
  localparam int RL_W = 3;

  // low-bit mask selecting cycle bits below the repetition rate
  function automatic logic [5:0] rate_mask6(input logic [RL_W-1:0] rl);
    logic [5:0] ones;
    ones = '1;
    return ~(ones << rl);
  endfunction
endpackage

// File: rtl/dynseg_filter.sv
module dynseg_filter #(
  parameter int ID_W  = 4,
  parameter int CYC_W = 6,
  parameter int CUR_W = 7
) (
  input  logic                      pend,
  input  logic [ID_W-1:0]           id,
  input  logic [CYC_W-1:0]          base,
  input  logic [dynseg_pkg::RL_W-1:0] rep_log2,
  input  logic [CUR_W-1:0]          cur_id,
  input  logic [CYC_W-1:0]          cyc,
  output logic                      hit
);
  logic [CYC_W-1:0] mask;
  logic [CYC_W:0]   ones;

  always_comb begin
    ones = '1;
    mask = ones[CYC_W-1:0] & ~(ones[CYC_W-1:0] << rep_log2);
  end

  assign hit = pend && (CUR_W'(id) == cur_id) && ((cyc & mask) == base);
endmodule

// File: rtl/dynseg_pick.sv
module dynseg_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     match,
  output logic             hit,
  output logic             multi,
  output logic [IDX_W-1:0] sel
);
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  assign multi = ($countones(match) > 1);

  // R9
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (match[sel] && ((match & ((N'(1) << sel) - N'(1))) == '0)));
endmodule

// File: rtl/dynseg_pending.sv
module dynseg_pending #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] own_tx,
  input  logic [N-1:0] done_vec,
  output logic [N-1:0] pend
);
  logic [N-1:0] again_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i]    <= 1'b0;
        again_q[i] <= 1'b0;
      end else if (done_vec[i]) begin
        pend[i]    <= again_q[i] | req[i];
        again_q[i] <= 1'b0;
      end else begin
        pend[i]    <= pend[i] | req[i];
        again_q[i] <= again_q[i] | (req[i] & own_tx[i]);
      end
    end
  end

  // R10
  done_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vec & ~pend) == '0);
endmodule

// File: rtl/dynseg_arbiter.sv
module dynseg_arbiter #(
  parameter int N_MSG = 4,
  parameter int ID_W  = 4,
  parameter int MS_W  = 6,
  parameter int CYC_W = 6,
  parameter int RL_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [MS_W-1:0]               cfg_seg_len,
  input  logic [CYC_W:0]                cfg_cc_max,
  input  logic [MS_W-1:0]               cfg_latest,
  input  logic [N_MSG*ID_W-1:0]         cfg_id,
  input  logic [N_MSG*CYC_W-1:0]        cfg_base,
  input  logic [N_MSG*RL_W-1:0]         cfg_rep_log2,
  input  logic [N_MSG*MS_W-1:0]         cfg_len,
  input  logic [N_MSG-1:0]              req,
  input  logic                          seg_start,
  input  logic                          ms_tick,
  output logic                          gnt,
  output logic                          done,
  output logic [((N_MSG>1)?$clog2(N_MSG):1)-1:0] tx_idx,
  output logic                          busy,
  output logic [CYC_W-1:0]              cycle_no,
  output logic                          cfg_err
);
  localparam int IDX_W = (N_MSG > 1) ? $clog2(N_MSG) : 1;
  localparam int CUR_W = MS_W + 1;

  logic             seg_act_q, busy_q, gnt_q, done_q, err_q;
  logic [MS_W-1:0]  ms_used_q, rem_q;
  logic [CUR_W-1:0] cur_id_q;
  logic [IDX_W-1:0] idx_q;
  logic [CYC_W-1:0] cyc_q;
  logic [N_MSG-1:0] pend, match, done_vec, own_tx, sent_q;
  logic             hit, multi, step, room, in_time, go, fin, last;
  logic [IDX_W-1:0] sel, fin_idx;
  logic [MS_W-1:0]  sel_len;

  for (genvar i = 0; i < N_MSG; i++) begin : g_filt
    dynseg_filter #(.ID_W(ID_W), .CYC_W(CYC_W), .CUR_W(CUR_W)) u_filt (
      .pend     (pend[i]),
      .id       (cfg_id[i*ID_W +: ID_W]),
      .base     (cfg_base[i*CYC_W +: CYC_W]),
      .rep_log2 (cfg_rep_log2[i*RL_W +: RL_W]),
      .cur_id   (cur_id_q),
      .cyc      (cyc_q),
      .hit      (match[i])
    );
  end

  dynseg_pick #(.N(N_MSG), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .match(match),
    .hit(hit), .multi(multi), .sel(sel)
  );

  dynseg_pending #(.N(N_MSG)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(req),
    .own_tx(own_tx), .done_vec(done_vec), .pend(pend)
  );

  assign sel_len = cfg_len[sel*MS_W +: MS_W];
  assign step    = ms_tick & seg_act_q;
  assign room    = sel_len <= (cfg_seg_len - ms_used_q);
  assign in_time = ms_used_q <= cfg_latest;
  assign go      = step & ~busy_q & hit & room & in_time & (sel_len != '0);
  assign fin     = step & ((busy_q & (rem_q == MS_W'(1))) | (go & (sel_len == MS_W'(1))));
  assign fin_idx = busy_q ? idx_q : sel;
  assign last    = step & ((ms_used_q + MS_W'(1)) == cfg_seg_len);

  always_comb begin
    for (int i = 0; i < N_MSG; i++) begin
      done_vec[i] = fin & (fin_idx == IDX_W'(i));
      own_tx[i]   = (busy_q & (idx_q == IDX_W'(i))) | (go & (sel == IDX_W'(i)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_act_q <= 1'b0;
      busy_q    <= 1'b0;
      gnt_q     <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      ms_used_q <= '0;
      rem_q     <= '0;
      cur_id_q  <= '0;
      idx_q     <= '0;
      cyc_q     <= '0;
      sent_q    <= '0;
    end else begin
      gnt_q  <= go;
      done_q <= fin;
      if (go) idx_q <= sel;
      if (step & ~busy_q & multi) err_q <= 1'b1;
      if (!seg_act_q && seg_start) begin
        seg_act_q <= 1'b1;
        ms_used_q <= '0;
        cur_id_q  <= CUR_W'(1);
        busy_q    <= 1'b0;
        sent_q    <= '0;
      end else if (step) begin
        sent_q    <= sent_q | done_vec;
        ms_used_q <= ms_used_q + MS_W'(1);
        if (busy_q) begin
          rem_q <= rem_q - MS_W'(1);
          if (rem_q == MS_W'(1)) begin
            busy_q   <= 1'b0;
            cur_id_q <= cur_id_q + CUR_W'(1);
          end
        end else if (go && sel_len != MS_W'(1)) begin
          busy_q <= 1'b1;
          rem_q  <= sel_len - MS_W'(1);
        end else begin
          cur_id_q <= cur_id_q + CUR_W'(1);
        end
        if (last) begin
          seg_act_q <= 1'b0;
          busy_q    <= 1'b0;
          cyc_q     <= ({1'b0, cyc_q} == cfg_cc_max - (CYC_W+1)'(1)) ? '0 : cyc_q + CYC_W'(1);
        end
      end
    end
  end

  assign gnt      = gnt_q;
  assign done     = done_q;
  assign tx_idx   = idx_q;
  assign busy     = busy_q;
  assign cycle_no = cyc_q;
  assign cfg_err  = err_q;

  // R1
  cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_act_q |-> ({1'b0, cyc_q} < cfg_cc_max));
  // R3
  id_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_act_q && $past(seg_act_q)) |-> (cur_id_q >= $past(cur_id_q)));
  // R4
  rem_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q != '0));
  // R12
  seg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (({1'b0, ms_used_q} + {1'b0, rem_q}) <= {1'b0, cfg_seg_len}));
  // R6
  once_per_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !sent_q[fin_idx]);
endmodule

// File: tb/dynseg_arbiter_tb.sv
module dynseg_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [5:0]  cfg_seg_len = 6'd8;
  logic [6:0]  cfg_cc_max  = 7'd4;
  logic [5:0]  cfg_latest  = 6'd6;
  // entries m3..m0
  logic [15:0] cfg_id       = {4'd3, 4'd2, 4'd2, 4'd1};
  logic [23:0] cfg_base     = {6'd0, 6'd1, 6'd0, 6'd0};
  logic [11:0] cfg_rep_log2 = {3'd0, 3'd1, 3'd1, 3'd1};
  logic [23:0] cfg_len      = {6'd1, 6'd3, 6'd6, 6'd5};
  logic [3:0]  req = '0;
  logic        seg_start = 1'b0, ms_tick = 1'b0;
  logic        gnt, done, busy, cfg_err;
  logic [1:0]  tx_idx;
  logic [5:0]  cycle_no;

  dynseg_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_seg_len(cfg_seg_len), .cfg_cc_max(cfg_cc_max),
    .cfg_latest(cfg_latest), .cfg_id(cfg_id), .cfg_base(cfg_base),
    .cfg_rep_log2(cfg_rep_log2), .cfg_len(cfg_len), .req(req),
    .seg_start(seg_start), .ms_tick(ms_tick), .gnt(gnt), .done(done),
    .tx_idx(tx_idx), .busy(busy), .cycle_no(cycle_no), .cfg_err(cfg_err)
  );

  int n_chk = 0, n_bad = 0;
  int ngnt, ndone, g0t, g0i, g1t, g1i, start_cyc;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run_seg(input logic [3:0] rq, input logic [5:0] lat,
                         input logic [3:0] mid_rq, input logic mid_start);
    cfg_latest = lat;
    ngnt = 0; ndone = 0; g0t = -1; g0i = -1; g1t = -1; g1i = -1;
    @(negedge clk) req = rq;
    @(negedge clk) req = '0;
    start_cyc = cycle_no;
    seg_start = 1'b1;
    @(negedge clk) seg_start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ms_tick = 1'b1;
      if (k == 3) begin
        req = mid_rq;
        seg_start = mid_start;
      end
      @(negedge clk);
      ms_tick = 1'b0;
      req = '0;
      seg_start = 1'b0;
      if (gnt) begin
        if (ngnt == 0) begin g0t = k; g0i = tx_idx; end
        else if (ngnt == 1) begin g1t = k; g1i = tx_idx; end
        ngnt++;
      end
      if (done) ndone++;
    end
    @(negedge clk);
  endtask

  // fields: req[33:30] lat[29:24] cyc[23:18] ngnt[17:15] g0t[14:11] g0i[10:9] g1t[8:5] g1i[4:3] ndone[2:0]
  localparam int NV = 8;
  localparam logic [33:0] VEC [NV] = '{
    {4'b1011, 6'd6, 6'd0, 3'd2, 4'd0, 2'd0, 4'd6, 2'd3, 3'd2}, // m1 misses: 6 > 3 left (R5), R8 edge at 6
    {4'b0100, 6'd6, 6'd1, 3'd1, 4'd1, 2'd2, 4'd0, 2'd0, 3'd1}, // R7 m2 shares id 2 in odd cycle
    {4'b1001, 6'd6, 6'd2, 3'd2, 4'd0, 2'd0, 4'd6, 2'd3, 3'd2}, // m1 still blocked
    {4'b0000, 6'd6, 6'd3, 3'd0, 4'd0, 2'd0, 4'd0, 2'd0, 3'd0}, // R2 m1 not eligible
    {4'b0000, 6'd6, 6'd0, 3'd1, 4'd1, 2'd1, 4'd0, 2'd0, 3'd1}, // R1 wrap, m1 finally sent
    {4'b0100, 6'd0, 6'd1, 3'd0, 4'd0, 2'd0, 4'd0, 2'd0, 3'd0}, // R8 too late
    {4'b0000, 6'd6, 6'd2, 3'd0, 4'd0, 2'd0, 4'd0, 2'd0, 3'd0}, // m2 filtered out
    {4'b0000, 6'd6, 6'd3, 3'd1, 4'd1, 2'd2, 4'd0, 2'd0, 3'd1}  // R10 m2 kept pending
  };

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset cycle", cycle_no, 0);
    check("R4 reset gnt", gnt, 0);
    check("R4 reset done", done, 0);
    check("R4 reset busy", busy, 0);
    check("R9 reset err", cfg_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_seg(VEC[v][33:30], VEC[v][29:24], 4'b0000, 1'b0);
      check("R1 cycle at segment start", start_cyc, int'(VEC[v][23:18]));
      check("R2 R5 R7 R8 grant count", ngnt, int'(VEC[v][17:15]));
      if (VEC[v][17:15] > 0) begin
        check("R3 R4 first grant tick", g0t, int'(VEC[v][14:11]));
        check("R4 first grant index", g0i, int'(VEC[v][10:9]));
      end
      if (VEC[v][17:15] > 1) begin
        check("R3 R5 second grant tick", g1t, int'(VEC[v][8:5]));
        check("R4 second grant index", g1i, int'(VEC[v][4:3]));
      end
      check("R4 R12 done count", ndone, int'(VEC[v][2:0]));
    end

    // R10 re-request during own transmission, R11 stray start mid-segment
    run_seg(4'b0001, 6'd6, 4'b0001, 1'b1);
    check("R11 cycle", start_cyc, 0);
    check("R11 grants with stray start", ngnt, 1);
    check("R4 grant m0", g0i, 0);
    check("R6 single done", ndone, 1);
    run_seg(4'b0000, 6'd6, 4'b0000, 1'b0);
    check("R2 m0 filtered in cycle 1", ngnt, 0);

    // R11 ticks while idle
    ngnt = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
      if (gnt) ngnt++;
    end
    check("R11 idle tick grants", ngnt, 0);
    check("R11 idle tick cycle", cycle_no, 2);

    // R9 collision: m3 moved to id 1, both m0 (re-request) and m3 pending
    cfg_id = {4'd1, 4'd2, 4'd2, 4'd1};
    run_seg(4'b1000, 6'd6, 4'b0000, 1'b0);
    check("R10 held request granted", ngnt, 1);
    check("R9 lower index wins", g0i, 0);
    check("R9 error flag", cfg_err, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule